// File: doc/BRIEF.md
# Input Activity Monitor with Change Interrupt

The block watches a bank of asynchronous data inputs for signs of life. Each input has a small detector that counts transitions. An input counts as active once it has toggled twice within one observation window. A slow, externally supplied monitor clock closes each window. On its rising edge every detector's verdict is latched into a read-only status bit, and the detector then starts over.

Status bits sit four to a register in a small block of read-only addresses. A controller reads them over a parallel bus using an active-low chip select and an active-low read strobe. Whenever a capture alters any bit of a register, that register's pending flag is raised and the active-low interrupt output goes low. The controller then reads the flagged registers. Each read clears only that register's flag and leaves the status untouched, so the interrupt stays low until every changed register has been read.

The monitor clock, the data inputs, chip select and read strobe are all sampled in the system clock domain. The monitor clock and the data inputs first pass through synchronizer chains.

Top module: `activity_monitor`

## Requirements
- R1: After reset every status bit reads 1, no pending flag is set, and `irq_n` is high.
- R2: An input that makes two or more transitions within a window reads 0 (activity seen) once the following monitor-clock rising edge has been captured.
- R3: An input that makes zero or one transition within a window reads 1 (no activity) after the capture.
- R4: Each capture restarts every detector, so an input that was active and then falls quiet reads 1 again after the next capture.
- R5: Input i is reported at address 0x22 + i/4, bit i%4. Address 0x2A carries inputs 32 and 33 in bits 0 and 1.
- R6: `rd_data` is 0 when `cs_n` or `rd_n` is high. It is also 0 at any address outside 0x22..0x2A, and in bits 2..5 of address 0x2A and bits 4..5 of the other status addresses.
- R7: `irq_n` falls only after a capture that changes at least one status bit. A capture that repeats the previous status leaves `irq_n` high.
- R8: A read of a status register clears that register's pending flag and leaves its status bits unchanged.
- R9: When several registers change in one capture, `irq_n` stays low until each of them has been read.
- R10: If a read of a register and a capture that changes that same register take effect in the same cycle, the flag stays set and `irq_n` stays low.
- R11: A read of an address outside the status range clears no pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 34 | Monitored data inputs, asynchronous |
| mon_clk | input | 1 | Monitor clock; each rising edge closes a window |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 6 | Register address |
| rd_data | output | 6 | Read-back data, 0 when not reading |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The delicate case is a read-clear and a flag-set that land on the same status register in the same cycle. The bench provokes it as follows. It leaves one register's flag pending, toggles an input of that register twice, and raises the monitor clock. It then starts the read of that register on the exact cycle in which the synchronized monitor-clock edge is captured. The bench judges the outcome by `irq_n`: it must still be low after that read. A later plain read must return the new status and release the interrupt.

// File: rtl/act_pkg.sv
package act_pkg;

    localparam int N_IN_DEF    = 34;
    localparam int GRP_DEF     = 4;
    localparam int ADDR_W_DEF  = 6;
    localparam int DATA_W_DEF  = 6;
    localparam int BASE_DEF    = 'h22;
    localparam int SYNC_DEF    = 2;

    // Transition count per detector, saturating at the "active" level.
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_ONE  = 2'd1,
        LVL_SEEN = 2'd2
    } act_lvl_e;

    // Decoded read request from the bus pins.
    typedef struct packed {
        logic active;
        logic start;
    } rd_req_t;

    function automatic int n_regs(input int n_in, input int grp);
        return (n_in + grp - 1) / grp;
    endfunction

    function automatic logic reg_hit(input int addr, input int base, input int r);
        return addr == base + r;
    endfunction

endpackage

// File: rtl/act_sync.sv
module act_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] tgl,
    output logic [W-1:0] rise
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= stg[LAST];
        end
    end

    assign lvl  = stg[LAST];
    assign tgl  = stg[LAST] ^ prev_q;
    assign rise = stg[LAST] & ~prev_q;
endmodule

// File: rtl/act_det_bank.sv
module act_det_bank
    import act_pkg::*;
#(
    parameter int N = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] tgl,
    input  logic         cap,
    output logic [N-1:0] seen
);
    for (genvar i = 0; i < N; i++) begin : g_det
        act_lvl_e cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= LVL_NONE;
            end else if (cap) begin
                // an edge in the closing cycle opens the next window
                cnt_q <= tgl[i] ? LVL_ONE : LVL_NONE;
            end else if (tgl[i]) begin
                case (cnt_q)
                    LVL_NONE: cnt_q <= LVL_ONE;
                    default:  cnt_q <= LVL_SEEN;
                endcase
            end
        end

        assign seen[i] = (cnt_q == LVL_SEEN);
    end
endmodule

// File: rtl/act_status_bank.sv
module act_status_bank #(
    parameter int N_IN  = 34,
    parameter int GRP   = 4,
    parameter int N_REG = 9,
    parameter int PADW  = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  seen,
    input  logic             cap,
    input  logic [N_REG-1:0] clr,
    output logic [PADW-1:0]  status,
    output logic [N_REG-1:0] pend
);
    logic [PADW-1:0] nxt;

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        for (genvar b = 0; b < GRP; b++) begin : g_bit
            localparam int IDX = r * GRP + b;
            if (IDX < N_IN) begin : g_live
                always_ff @(posedge clk) begin
                    if (rst) status[IDX] <= 1'b1;
                    else     status[IDX] <= nxt[IDX];
                end
                assign nxt[IDX] = cap ? ~seen[IDX] : status[IDX];
            end else begin : g_pad
                assign status[IDX] = 1'b0;
                assign nxt[IDX]    = 1'b0;
            end
        end

        logic chg;
        assign chg = nxt[r*GRP +: GRP] != status[r*GRP +: GRP];

        // a fresh change outranks a read-clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst)         pend[r] <= 1'b0;
            else if (chg)    pend[r] <= 1'b1;
            else if (clr[r]) pend[r] <= 1'b0;
        end
    end
endmodule

// File: rtl/act_rd_port.sv
module act_rd_port
    import act_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 6,
    parameter int GRP    = 4,
    parameter int N_REG  = 9,
    parameter int PADW   = 36,
    parameter int BASE   = 'h22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PADW-1:0]   status,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_start,
    output logic [N_REG-1:0]  clr
);
    rd_req_t req;
    logic    act_q;

    assign req.active = ~cs_n & ~rd_n;
    assign req.start  = req.active & ~act_q;
    assign rd_start   = req.start;

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= req.active;
    end

    always_comb begin
        rd_data = '0;
        clr     = '0;
        for (int r = 0; r < N_REG; r++) begin
            if (req.active && reg_hit(int'(addr), BASE, r)) begin
                rd_data[GRP-1:0] = status[r*GRP +: GRP];
                clr[r]           = req.start;
            end
        end
    end
endmodule

// File: rtl/activity_monitor.sv
module activity_monitor
    import act_pkg::*;
#(
    parameter int N_IN   = N_IN_DEF,
    parameter int GRP    = GRP_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int BASE   = BASE_DEF,
    parameter int STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   din,
    input  logic              mon_clk,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    localparam int N_REG = n_regs(N_IN, GRP);
    localparam int PADW  = N_REG * GRP;

    logic [N_IN-1:0]  din_lvl, din_tgl, din_rise;
    logic             mc_lvl, mc_tgl, cap_stb;
    logic [N_IN-1:0]  seen;
    logic [PADW-1:0]  status;
    logic [N_REG-1:0] pend, clr;
    logic             rd_start;

    act_sync #(.W(N_IN), .STAGES(STAGES)) u_din_sync (
        .clk(clk), .rst(rst), .d(din),
        .lvl(din_lvl), .tgl(din_tgl), .rise(din_rise)
    );

    act_sync #(.W(1), .STAGES(STAGES)) u_mc_sync (
        .clk(clk), .rst(rst), .d(mon_clk),
        .lvl(mc_lvl), .tgl(mc_tgl), .rise(cap_stb)
    );

    act_det_bank #(.N(N_IN)) u_det (
        .clk(clk), .rst(rst), .tgl(din_tgl), .cap(cap_stb), .seen(seen)
    );

    act_status_bank #(.N_IN(N_IN), .GRP(GRP), .N_REG(N_REG), .PADW(PADW)) u_stat (
        .clk(clk), .rst(rst), .seen(seen), .cap(cap_stb),
        .clr(clr), .status(status), .pend(pend)
    );

    act_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRP(GRP), .N_REG(N_REG),
                  .PADW(PADW), .BASE(BASE)) u_rd (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .status(status), .rd_data(rd_data), .rd_start(rd_start), .clr(clr)
    );

    assign irq_n = ~(|pend);

    logic unused_ok;
    assign unused_ok = ^{din_lvl, din_rise, mc_lvl, mc_tgl};
endmodule

// File: rtl/activity_monitor_chk.sv
module activity_monitor_chk #(
    parameter int N_IN   = 34,
    parameter int PADW   = 36,
    parameter int DATA_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_n,
    input logic              cap_stb,
    input logic              rd_start,
    input logic [PADW-1:0]   status
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_n && (&status[N_IN-1:0])));

    a_r6_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (rd_data == '0));

    a_r7_irq_needs_capture: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(cap_stb));

    a_r8_status_only_on_capture: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> $stable(status));

    a_r9_release_needs_read: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n) |-> $past(rd_start));
endmodule

bind activity_monitor activity_monitor_chk #(.N_IN(N_IN), .PADW(PADW), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .rd_data(rd_data),
    .irq_n(irq_n), .cap_stb(cap_stb), .rd_start(rd_start), .status(status)
);

// File: tb/activity_monitor_tb.sv
module activity_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 34;
    localparam int NREG  = 9;
    localparam int BASE  = 'h22;

    // each entry: {inputs toggled twice, inputs toggled once}
    localparam logic [67:0] VEC [0:4] = '{
        {34'h3_0000_0001, 34'h0_0000_0010},
        {34'h0_FFFF_0000, 34'h0_0000_0003},
        {34'h0_0000_0000, 34'h0_0000_0000},
        {34'h2_AAAA_5555, 34'h0_0000_0000},
        {34'h2_AAAA_5555, 34'h1_0000_0000}
    };

    logic          clk = 0;
    logic          rst = 1;
    logic [N-1:0]  din = '0;
    logic          mon_clk = 0;
    logic          cs_n = 1, rd_n = 1;
    logic [5:0]    addr = '0;
    logic [5:0]    rd_data;
    logic          irq_n;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [N-1:0] stat_m = '1;
    logic [NREG-1:0] pend_m = '0;

    activity_monitor u_dut (
        .clk(clk), .rst(rst), .din(din), .mon_clk(mon_clk), .cs_n(cs_n),
        .rd_n(rd_n), .addr(addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_reg(input int a);
        int v = 0;
        if (a >= BASE && a < BASE + NREG)
            for (int b = 0; b < 4; b++)
                if ((a - BASE) * 4 + b < N) v |= int'(stat_m[(a - BASE) * 4 + b]) << b;
        return v;
    endfunction

    task automatic do_read(input int a, output int d);
        @(negedge clk);
        addr = a[5:0]; cs_n = 0; rd_n = 0;
        @(posedge clk); #1;
        d = int'(rd_data);
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        if (a >= BASE && a < BASE + NREG) pend_m[a - BASE] = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic toggles(input logic [N-1:0] two, input logic [N-1:0] one);
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            din = din ^ two ^ (p == 0 ? one : '0);
            repeat (3) @(posedge clk);
        end
        repeat (4) @(posedge clk);
    endtask

    function automatic void model_cap(input logic [N-1:0] two);
        logic [N-1:0] nw = ~two;
        for (int r = 0; r < NREG; r++)
            for (int b = 0; b < 4; b++)
                if (r * 4 + b < N && nw[r*4+b] != stat_m[r*4+b]) pend_m[r] = 1'b1;
        stat_m = nw;
    endfunction

    task automatic capture();
        @(negedge clk); mon_clk = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); mon_clk = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic window(input logic [N-1:0] two, input logic [N-1:0] one, input string req);
        toggles(two, one);
        capture();
        model_cap(two);
        check(req, int'(irq_n), int'(pend_m == '0));
    endtask

    task automatic read_all(input string req);
        int d;
        for (int a = BASE; a < BASE + NREG; a++) begin
            do_read(a, d);
            check(req, d, exp_reg(a));
        end
        @(negedge clk);
        check(req, int'(irq_n), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 irq after reset", int'(irq_n), 1);
        read_all("R1 R5 reset status");

        // R6: bus idle and unused addresses
        @(negedge clk); addr = 6'h22; cs_n = 1; rd_n = 0; #1;
        check("R6 cs high", int'(rd_data), 0);
        cs_n = 0; rd_n = 1; #1;
        check("R6 rd high", int'(rd_data), 0);
        cs_n = 1;
        do_read('h21, d); check("R6 below range", d, 0);
        do_read('h2B, d); check("R6 above range", d, 0);
        do_read('h3F, d); check("R6 top addr", d, 0);
        do_read('h2A, d); check("R6 R5 0x2A pad bits", d, 3);

        // table walk: R2, R3, R4, R5, R7
        for (int v = 0; v < 5; v++) begin
            window(VEC[v][67:34], VEC[v][33:0], "R2 R3 R4 R7 irq");
            read_all("R5 R2 R3 readback");
        end

        // R9 / R11 / R8: two registers change in one capture
        window('0, '0, "R4 quiet window");
        read_all("R4 quiet readback");
        window(34'h0_0010_0001, '0, "R7 two regs");
        do_read('h2B, d);
        check("R11 out of range read", int'(irq_n), 0);
        do_read('h22, d);
        check("R5 reg0 data", d, exp_reg('h22));
        check("R9 one of two read", int'(irq_n), 0);
        do_read('h27, d);
        check("R5 reg5 data", d, exp_reg('h27));
        check("R9 all read", int'(irq_n), 1);
        do_read('h22, d);
        check("R8 status kept", d, exp_reg('h22));

        // R10: read of 0x22 coincides with a capture that changes it
        window('0, '0, "R7 back to idle");
        do_read('h27, d);
        check("R10 only reg0 pending", int'(irq_n), 0);
        toggles(34'h1, '0);
        @(negedge clk); mon_clk = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); addr = 6'h22; cs_n = 0; rd_n = 0;
        @(posedge clk);
        @(negedge clk); cs_n = 1; rd_n = 1; mon_clk = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_cap(34'h1);
        check("R10 set wins", int'(irq_n), 0);
        do_read('h22, d);
        check("R10 new status", d, exp_reg('h22));
        check("R10 released", int'(irq_n), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule